// File: doc/BRIEF.md
# Offset-Range Bidirectional Decade Counter

This block is a four-bit synchronous counter whose ten legal states are the codes 3 through 12 (binary 0011 to 1100) rather than 0 through 9. On each enabled clock it steps one code up or one code down, as chosen by a direction pin. The range closes into a ring in both directions: 12 is followed by 3 when counting up, and 3 is followed by 12 when counting down.

A synchronous reset returns the count to 3, the first code of the range. A synchronous load places any four-bit value into the count. A loaded value outside the range is kept until the next enabled step, which pulls it to the range boundary the count would enter from that side: 3 when counting up, 12 when counting down. A combinational terminal-count pin marks the wrap point for the present direction while stepping is enabled. All pins are plain level-sampled controls; the block carries no streamed data, so no valid/ready handshake applies.

Top module: `ocnt_counter`

## Requirements
- R1: When `rst` is 1 at a rising clock edge, `count` becomes 3 (0011) after that edge, whatever `load_en`, `cnt_en` and `dir_up` are.
- R2: When `rst` is 0 and `load_en` is 1 at a rising edge, `count` becomes `load_val` after that edge for all sixteen values, regardless of `cnt_en` and `dir_up`.
- R3: When `rst`, `load_en` and `cnt_en` are all 0 at a rising edge, `count` keeps its value.
- R4: Counting up (`dir_up` = 1, `cnt_en` = 1, no reset or load) from a count of 3 to 11, the next count is the present count plus one.
- R5: Counting up from 12, the next count is 3.
- R6: Counting down (`dir_up` = 0, `cnt_en` = 1, no reset or load) from a count of 4 to 12, the next count is the present count minus one.
- R7: Counting down from 3, the next count is 12.
- R8: An enabled step from a count outside 3..12 (0, 1, 2, 13, 14, 15) gives 3 when counting up and 12 when counting down.
- R9: `term_cnt` is 1 exactly when `cnt_en` is 1 and either `dir_up` is 1 with `count` equal to 12, or `dir_up` is 0 with `count` equal to 3; it follows these inputs in the same cycle and ignores `rst` and `load_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, highest priority |
| load_en | input | 1 | Synchronous load strobe, second priority |
| load_val | input | 4 | Value placed in the count on a load |
| cnt_en | input | 1 | Step enable; count holds when low |
| dir_up | input | 1 | 1 counts up, 0 counts down |
| count | output | 4 | Present count |
| term_cnt | output | 1 | Wrap point reached for the present direction while enabled |

## Verification
Every cycle the assertions check the priority of reset over load over stepping, the hold when idle, the one-code step within the range, both wraps, the snap of out-of-range values to the boundary, and that an asserted terminal count is followed by the wrap target. What the assertions cannot show is that the ten codes form a complete ring with no skipped or repeated code, and that the snap applies to every one of the six illegal codes in both directions; the bench shows these by walking the ring more than twice each way and by loading all sixteen values and stepping each in both directions against an arithmetic model.

// File: rtl/ocnt_pkg.sv
package ocnt_pkg;

  // Default geometry of the counter.
  localparam int unsigned OCNT_W  = 4;
  localparam int unsigned OCNT_LO = 3;
  localparam int unsigned OCNT_HI = 12;

  // Count direction as driven on dir_up.
  typedef enum logic {
    CNT_DOWN = 1'b0,
    CNT_UP   = 1'b1
  } cnt_dir_e;

endpackage

// File: rtl/ocnt_step.sv
// Next-state for one enabled step: in-range move, wrap, or snap to boundary.
module ocnt_step
  import ocnt_pkg::*;
#(
  parameter int unsigned W  = OCNT_W,
  parameter int unsigned LO = OCNT_LO,
  parameter int unsigned HI = OCNT_HI
) (
  input  logic [W-1:0] cur,
  input  cnt_dir_e     dir,
  output logic [W-1:0] nxt
);

  localparam logic [W-1:0] LO_C = W'(LO);
  localparam logic [W-1:0] HI_C = W'(HI);

  logic can_inc;
  logic can_dec;

  always_comb begin
    can_inc = (cur >= LO_C) && (cur < HI_C);
    can_dec = (cur > LO_C) && (cur <= HI_C);
    if (dir == CNT_UP) begin
      // Top of range and illegal codes all land on the low boundary.
      nxt = can_inc ? cur + W'(1) : LO_C;
    end else begin
      // Bottom of range and illegal codes all land on the high boundary.
      nxt = can_dec ? cur - W'(1) : HI_C;
    end
  end

endmodule

// File: rtl/ocnt_term.sv
// Terminal-count detect for the present direction.
module ocnt_term
  import ocnt_pkg::*;
#(
  parameter int unsigned W  = OCNT_W,
  parameter int unsigned LO = OCNT_LO,
  parameter int unsigned HI = OCNT_HI
) (
  input  logic [W-1:0] cur,
  input  cnt_dir_e     dir,
  input  logic         en,
  output logic         tc
);

  localparam logic [W-1:0] LO_C = W'(LO);
  localparam logic [W-1:0] HI_C = W'(HI);

  logic at_edge;

  always_comb begin
    if (dir == CNT_UP) at_edge = (cur == HI_C);
    else               at_edge = (cur == LO_C);
    tc = en && at_edge;
  end

endmodule

// File: rtl/ocnt_counter.sv
// Offset-range bidirectional decade counter, top level.
module ocnt_counter
  import ocnt_pkg::*;
#(
  parameter int unsigned W  = OCNT_W,
  parameter int unsigned LO = OCNT_LO,
  parameter int unsigned HI = OCNT_HI
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         cnt_en,
  input  logic         dir_up,
  output logic [W-1:0] count,
  output logic         term_cnt
);

  localparam logic [W-1:0] LO_C = W'(LO);
  localparam logic [W-1:0] HI_C = W'(HI);

  cnt_dir_e     dir;
  logic [W-1:0] count_q;
  logic [W-1:0] step_nxt;

  assign dir = cnt_dir_e'(dir_up);

  ocnt_step #(.W(W), .LO(LO), .HI(HI)) u_step (
    .cur (count_q),
    .dir (dir),
    .nxt (step_nxt)
  );

  ocnt_term #(.W(W), .LO(LO), .HI(HI)) u_term (
    .cur (count_q),
    .dir (dir),
    .en  (cnt_en),
    .tc  (term_cnt)
  );

  // Priority: reset, then load, then enabled step, else hold.
  always_ff @(posedge clk) begin
    if (rst)          count_q <= LO_C;
    else if (load_en) count_q <= load_val;
    else if (cnt_en)  count_q <= step_nxt;
  end

  assign count = count_q;

  // R1: reset wins over everything.
  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> count == LO_C);

  // R2: load takes any value.
  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    load_en |=> count == $past(load_val));

  // R3: idle holds.
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !cnt_en) |=> $stable(count));

  // R4: in-range up step.
  a_r4_inc: assert property (@(posedge clk) disable iff (rst)
    (!load_en && cnt_en && dir_up && count >= LO_C && count < HI_C)
      |=> count == $past(count) + W'(1));

  // R5: up wrap.
  a_r5_wrap_up: assert property (@(posedge clk) disable iff (rst)
    (!load_en && cnt_en && dir_up && count == HI_C) |=> count == LO_C);

  // R6: in-range down step.
  a_r6_dec: assert property (@(posedge clk) disable iff (rst)
    (!load_en && cnt_en && !dir_up && count > LO_C && count <= HI_C)
      |=> count == $past(count) - W'(1));

  // R7: down wrap.
  a_r7_wrap_dn: assert property (@(posedge clk) disable iff (rst)
    (!load_en && cnt_en && !dir_up && count == LO_C) |=> count == HI_C);

  // R8: illegal codes snap to the boundary of the direction.
  a_r8_snap: assert property (@(posedge clk) disable iff (rst)
    (!load_en && cnt_en && (count < LO_C || count > HI_C))
      |=> count == ($past(dir_up) ? LO_C : HI_C));

  // R9: an asserted terminal count is followed by the wrap target.
  a_r9_term_wrap: assert property (@(posedge clk) disable iff (rst)
    (term_cnt && !load_en) |=> count == ($past(dir_up) ? LO_C : HI_C));

  a_r9_term_needs_en: assert property (@(posedge clk) disable iff (rst)
    term_cnt |-> cnt_en);

endmodule

// File: tb/test_ocnt_counter.sv
`timescale 1ns/1ps
module test_ocnt_counter;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_en = 1'b0;
  logic [3:0] load_val = 4'd0;
  logic       cnt_en = 1'b0;
  logic       dir_up = 1'b1;
  logic [3:0] count;
  logic       term_cnt;

  int checks = 0;
  int failures = 0;
  int exp_cnt = 0;
  bit known = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ocnt_counter i_ocnt_counter (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .load_val (load_val),
    .cnt_en   (cnt_en),
    .dir_up   (dir_up),
    .count    (count),
    .term_cnt (term_cnt)
  );

  function automatic int model_step(int cur, bit up);
    if (up) return (cur >= 3 && cur <= 11) ? cur + 1 : 3;
    else    return (cur >= 4 && cur <= 12) ? cur - 1 : 12;
  endfunction

  // One clock: drive at negedge, check term_cnt before the edge,
  // check count one ns after the edge.
  task automatic cycle(bit r, bit ld, int lv, bit en, bit up);
    string tag;
    int nxt;
    bit exp_tc;
    @(negedge clk);
    rst = r; load_en = ld; load_val = 4'(lv); cnt_en = en; dir_up = up;
    #0.5;
    if (known) begin
      exp_tc = en && ((up && exp_cnt == 12) || (!up && exp_cnt == 3));
      checks++;
      if (term_cnt !== exp_tc) begin
        failures++;
        $display("FAIL R9 term_cnt actual=%0b expected=%0b count=%0d", term_cnt, exp_tc, exp_cnt);
      end
    end
    if (r) begin tag = "R1"; nxt = 3; end
    else if (ld) begin tag = "R2"; nxt = lv; end
    else if (!en) begin tag = "R3"; nxt = exp_cnt; end
    else begin
      nxt = model_step(exp_cnt, up);
      if (exp_cnt < 3 || exp_cnt > 12) tag = "R8";
      else if (up) tag = (exp_cnt == 12) ? "R5" : "R4";
      else tag = (exp_cnt == 3) ? "R7" : "R6";
    end
    @(posedge clk);
    #1;
    if (known || r || ld) begin
      exp_cnt = nxt;
      known = 1'b1;
      checks++;
      if (count !== 4'(exp_cnt)) begin
        failures++;
        $display("FAIL %s count actual=%0d expected=%0d", tag, count, exp_cnt);
      end
    end
  endtask

  initial begin
    // R1: reset state, also with load and enable asserted.
    cycle(1, 0, 0, 0, 1);
    cycle(1, 1, 9, 1, 0);
    // R4/R5: walk the ring upwards more than twice.
    for (int i = 0; i < 25; i++) cycle(0, 0, 0, 1, 1);
    // R6/R7: and downwards.
    for (int i = 0; i < 25; i++) cycle(0, 0, 0, 1, 0);
    // R3: hold with both directions, including at the boundaries.
    cycle(0, 1, 12, 0, 1);
    for (int i = 0; i < 3; i++) cycle(0, 0, 0, 0, i[0]);
    cycle(0, 1, 3, 0, 0);
    for (int i = 0; i < 3; i++) cycle(0, 0, 0, 0, i[0]);
    // R2/R8/R4..R7: every load value, then a step each way.
    for (int v = 0; v < 16; v++) begin
      for (int d = 0; d < 2; d++) begin
        cycle(0, 1, v, 1, d[0] ^ 1'b1);     // load beats enable
        cycle(0, 0, 0, 1, d[0]);            // one step
        cycle(0, 0, 0, 1, d[0]);            // second step
      end
    end
    // R3: illegal value held while disabled.
    cycle(0, 1, 14, 0, 1);
    cycle(0, 0, 0, 0, 1);
    cycle(0, 0, 0, 0, 0);
    // R1: reset beats load mid-count.
    cycle(0, 1, 8, 0, 1);
    cycle(1, 1, 15, 1, 1);
    // Mixed direction changes.
    for (int i = 0; i < 40; i++) cycle(0, (i % 13) == 7, (i * 5) % 16, (i % 4) != 3, i[1]);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule